// File: doc/BRIEF.md
# Composable Add/AND ALU Slice

This block is a parameterized-width arithmetic/logic unit whose function is built from a few independent control bits rather than decoded from an opcode. Each of the two operands, X and Y, passes through its own conditioning stage. That stage can first clear the operand to zero and then invert every bit of the value it holds.

The two conditioned operands reach a ripple-carry adder, which has an explicit carry input, and a bitwise AND. A function-select bit picks one of the two. The picked value can be bitwise inverted before it leaves the block. Combining these controls yields constants, negation, increment, decrement, subtraction and the logic operations.

The result, a zero flag and the adder carry-out are captured in output registers. The registers have a synchronous active-high reset, so a result appears one clock after its inputs are presented.

Top module: `cfg_alu_slice`

## Requirements
- R1: A rising clock edge with `rst` high sets `res` to 0, `res_zero` to 1 and `carry_out` to 0, whatever the data and control inputs are.
- R2: Outside reset, the outputs present after a rising edge are computed from the inputs sampled at that edge, so the latency is exactly one clock.
- R3: `zero_x`=1 replaces X with all zeros, and `zero_y`=1 replaces Y with all zeros, before any inversion.
- R4: `inv_x`=1 bitwise inverts the X value left by the zeroing step, and `inv_y`=1 does the same for Y.
- R5: With `fn_add`=1, the selected value is (X' + Y' + `carry_in`) modulo 2^W, and `carry_out` is bit W of that full sum.
- R6: With `fn_add`=0, the selected value is X' AND Y', `carry_out` is 0, and `carry_in` has no effect on any output.
- R7: `inv_out`=1 bitwise inverts the selected value to form `res`. The carry-out is not inverted.
- R8: `res_zero` is 1 exactly when every bit of `res` is 0.
- R9: With both operands zeroed, `inv_x`=1, `inv_y`=0, add selected, `carry_in`=0 and `inv_out`=0, `res` is all ones and `carry_out` is 0. Setting `inv_y`=1 as well gives all ones except bit 0, with `carry_out`=1.
- R10: The width W is a parameter with a default of 16. The zero flag covers all W bits, so a lone set most-significant bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_x | input | W | Operand X |
| op_y | input | W | Operand Y |
| zero_x | input | 1 | Clear X before inversion |
| inv_x | input | 1 | Invert conditioned X |
| zero_y | input | 1 | Clear Y before inversion |
| inv_y | input | 1 | Invert conditioned Y |
| fn_add | input | 1 | 1 selects the sum, 0 selects the bitwise AND |
| inv_out | input | 1 | Invert the selected value |
| carry_in | input | 1 | Carry into the adder's least-significant bit |
| res | output | W | Registered result |
| res_zero | output | 1 | Registered all-zero flag of the result |
| carry_out | output | 1 | Registered adder carry-out, 0 in AND mode |

## Verification
The result, the zero flag and the carry-out all fall due on the first rising edge after their inputs are sampled. Nothing in this block takes longer than that.

The bench therefore changes the stimulus on a falling edge. It records the expected triple from a behavioural model at that moment and compares all three outputs at the next falling edge. That falling edge lies half a period after the capturing edge and half a period before the next one.

Reset values are checked the same way, at the falling edge after a reset edge. During that reset the data and control inputs are held at non-zero values.

// File: rtl/cfg_alu_pkg.sv
package cfg_alu_pkg;

  // Per-operation control word, assembled from the top-level pins
  typedef struct packed {
    logic zero_x;
    logic inv_x;
    logic zero_y;
    logic inv_y;
    logic fn_add;
    logic inv_out;
  } alu_ctrl_t;

  localparam int CTRL_BITS = $bits(alu_ctrl_t);

endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
  parameter int W = 16
) (
  input  logic         zero_en,
  input  logic         inv_en,
  input  logic [W-1:0] opnd_i,
  output logic [W-1:0] opnd_o
);

  logic [W-1:0] cleared;

  // Zeroing comes first and inversion second, so a cleared operand that is
  // then inverted becomes all ones.
  always_comb begin
    cleared = zero_en ? '0 : opnd_i;
    opnd_o  = inv_en ? ~cleared : cleared;
  end

  always_comb begin
    if (zero_en === 1'b1 && inv_en === 1'b0)
      a_r3_cleared_is_zero: assert (opnd_o == '0);
    if (zero_en === 1'b1 && inv_en === 1'b1)
      a_r4_cleared_inverted_ones: assert (opnd_o == '1);
    if (zero_en === 1'b0 && inv_en === 1'b1 && !$isunknown(opnd_i))
      a_r4_plain_inversion: assert ((opnd_o ^ opnd_i) == '1);
  end

endmodule

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] chain;

  assign chain[0] = cin;

  // One full-adder cell per bit, linked through the carry chain
  for (genvar i = 0; i < W; i++) begin : g_fa
    logic half;
    assign half        = a[i] ^ b[i];
    assign sum[i]      = half ^ chain[i];
    assign chain[i+1]  = (a[i] & b[i]) | (half & chain[i]);
  end

  assign cout = chain[W];

  always_comb begin
    if (!$isunknown({a, b, cin}))
      a_r5_ripple_matches_sum: assert ({cout, sum} ==
        ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}));
  end

endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage
  import cfg_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_ctrl_t    ctrl,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] sum,
  input  logic         add_cout,
  output logic [W-1:0] res_n,
  output logic         zero_n,
  output logic         cout_n
);

  logic [W-1:0] picked;

  always_comb begin
    picked = ctrl.fn_add ? sum : (a & b);
    res_n  = ctrl.inv_out ? ~picked : picked;
    zero_n = ~|res_n;
    cout_n = ctrl.fn_add & add_cout;
  end

  always_comb begin
    if (ctrl.fn_add === 1'b0)
      a_r6_and_mode_no_carry: assert (cout_n == 1'b0);
  end

endmodule

// File: rtl/cfg_alu_slice.sv
module cfg_alu_slice
  import cfg_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_x,
  input  logic [W-1:0] op_y,
  input  logic         zero_x,
  input  logic         inv_x,
  input  logic         zero_y,
  input  logic         inv_y,
  input  logic         fn_add,
  input  logic         inv_out,
  input  logic         carry_in,
  output logic [W-1:0] res,
  output logic         res_zero,
  output logic         carry_out
);

  alu_ctrl_t    ctrl;
  logic [W-1:0] x_c, y_c, sum_w, res_n;
  logic         add_cout, zero_n, cout_n;

  assign ctrl = '{zero_x: zero_x, inv_x: inv_x, zero_y: zero_y,
                  inv_y: inv_y, fn_add: fn_add, inv_out: inv_out};

  alu_operand_cond #(.W(W)) u_cond_x (
    .zero_en(ctrl.zero_x), .inv_en(ctrl.inv_x), .opnd_i(op_x), .opnd_o(x_c)
  );

  alu_operand_cond #(.W(W)) u_cond_y (
    .zero_en(ctrl.zero_y), .inv_en(ctrl.inv_y), .opnd_i(op_y), .opnd_o(y_c)
  );

  alu_ripple_add #(.W(W)) u_add (
    .a(x_c), .b(y_c), .cin(carry_in), .sum(sum_w), .cout(add_cout)
  );

  alu_out_stage #(.W(W)) u_out (
    .ctrl(ctrl), .a(x_c), .b(y_c), .sum(sum_w), .add_cout(add_cout),
    .res_n(res_n), .zero_n(zero_n), .cout_n(cout_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      res_zero  <= 1'b1;
      carry_out <= 1'b0;
    end else begin
      res       <= res_n;
      res_zero  <= zero_n;
      carry_out <= cout_n;
    end
  end

  a_r6_and_clears_carry: assert property (@(posedge clk) disable iff (rst)
    !fn_add |=> !carry_out);

  a_r8_flag_tracks_result: assert property (@(posedge clk) disable iff (rst)
    res_zero == (res == '0));

  a_r2_steady_in_steady_out: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable({op_x, op_y, ctrl, carry_in}))
      |=> $stable({res, res_zero, carry_out}));

endmodule

// File: tb/sim_cfg_alu_slice.sv
module sim_cfg_alu_slice;
  localparam int W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic [W-1:0] op_x = '0, op_y = '0;
  logic zero_x = 0, inv_x = 0, zero_y = 0, inv_y = 0;
  logic fn_add = 0, inv_out = 0, carry_in = 0;
  logic [W-1:0] res;
  logic res_zero, carry_out;

  int total = 0, bad = 0;
  bit done = 0;

  logic [W-1:0] exp_res;
  logic         exp_c;
  string        exp_tag;

  cfg_alu_slice #(.W(W)) u0 (
    .clk(clk), .rst(rst), .op_x(op_x), .op_y(op_y),
    .zero_x(zero_x), .inv_x(inv_x), .zero_y(zero_y), .inv_y(inv_y),
    .fn_add(fn_add), .inv_out(inv_out), .carry_in(carry_in),
    .res(res), .res_zero(res_zero), .carry_out(carry_out)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Present one vector right after a falling edge and record the model's answer
  task automatic drive(input bit zx, nx, zy, ny, f, no,
                       input logic [W-1:0] x, y, input bit ci, input string extra);
    logic [W-1:0] xa, ya, r;
    logic [W:0]   s;
    op_x = x; op_y = y; zero_x = zx; inv_x = nx; zero_y = zy; inv_y = ny;
    fn_add = f; inv_out = no; carry_in = ci;
    xa = zx ? '0 : x;
    if (nx) xa = ~xa;
    ya = zy ? '0 : y;
    if (ny) ya = ~ya;
    if (f) begin
      s = {1'b0, xa} + {1'b0, ya} + W'(ci);
      r = s[W-1:0];
      exp_c = s[W];
    end else begin
      r = xa & ya;
      exp_c = 1'b0;
    end
    exp_res = no ? ~r : r;
    exp_tag = {"R2 ", (f ? "R5" : "R6"), (no ? " R7" : ""), extra};
  endtask

  // Outputs are due at the edge after the drive; sample at the next falling edge
  task automatic settle_and_check();
    @(negedge clk);
    check({exp_tag, " res"}, res, exp_res);
    check({exp_tag, " carry"}, W'(carry_out), W'(exp_c));
    check("R8 zero flag", W'(res_zero), W'(exp_res == '0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: hold reset with busy inputs
    drive(0, 1, 0, 0, 1, 1, 16'h1234, 16'h4321, 1, "");
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 reset res", res, '0);
    check("R1 reset zero flag", W'(res_zero), W'(1'b1));
    check("R1 reset carry", W'(carry_out), '0);
    rst = 1'b0;

    // R9: constant patterns
    drive(1, 1, 1, 0, 1, 0, 16'hA5A5, 16'h5A5A, 0, " R9 allones");
    settle_and_check();
    drive(1, 1, 1, 1, 1, 0, 16'hA5A5, 16'h5A5A, 0, " R9 fffe");
    settle_and_check();
    // R3: both cleared, add gives zero
    drive(1, 0, 1, 0, 1, 0, 16'h1234, 16'hFFFF, 0, " R3 clear");
    settle_and_check();
    // R4: inverted X with cleared Y
    drive(0, 1, 1, 0, 1, 0, 16'h00F0, 16'h7777, 0, " R4 invert");
    settle_and_check();
    // R6: carry-in ignored in AND mode
    drive(0, 0, 0, 0, 0, 0, 16'hF0F0, 16'hFF00, 1, " R6 cin ignored");
    settle_and_check();
    // R5: wrap-around with carry-out
    drive(0, 0, 0, 0, 1, 0, 16'hFFFF, 16'h0001, 0, " R5 wrap");
    settle_and_check();
    // R10: only the top bit set, then a full-width zero
    drive(0, 0, 0, 0, 0, 0, 16'h8000, 16'h8000, 0, " R10 msb");
    settle_and_check();
    drive(0, 0, 0, 0, 0, 0, 16'h8000, 16'h7FFF, 0, " R10 zero");
    settle_and_check();

    // Every control combination with random operands and carry-in
    for (int rnd = 0; rnd < 20; rnd++) begin
      for (int c = 0; c < 64; c++) begin
        drive(c[5], c[4], c[3], c[2], c[1], c[0],
              W'($urandom), W'($urandom), bit'($urandom), " sweep");
        settle_and_check();
      end
    end

    // R1 again: reset after activity
    drive(0, 0, 0, 0, 1, 0, 16'hFFFF, 16'hFFFF, 1, "");
    rst = 1'b1;
    @(negedge clk);
    check("R1 re-reset res", res, '0);
    check("R1 re-reset zero flag", W'(res_zero), W'(1'b1));
    check("R1 re-reset carry", W'(carry_out), '0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule